// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block stands in for the keyboard at the far end of a serial keyboard link. Key events enter as a 7-bit code with a press/release flag, and the host's command bytes enter from the serial channel's transmit side. Everything the keyboard would send back is placed in a byte queue. The serial controller drains that queue one byte per read, and uses `not_empty` to raise its receive-available indication.

Three command families are answered. An identification request and a layout query each flush the queue and load a fixed reply. An LED command causes the next command byte to be taken as LED data and discarded. The two lock keys pass through a small filter, so that only every other press/release pair reaches the host. When a reply and a key event land in the same cycle, the reply wins and the key byte follows one cycle later. `DEPTH` must be a power of two.

Top module: `kbd_responder`

## Requirements
- R1: After reset the queue is empty: `not_empty` is 0 and `rd_data` is 0x00.
- R2: A non-lock key event enqueues one byte. A press gives `{1'b0, keycode}` and a release gives `{1'b1, keycode}`. Bytes leave in arrival order.
- R3: An accepted command 0x01 discards the queue contents and leaves exactly 0xFF, 0x04, 0x7F, in that order, readable from the next cycle.
- R4: An accepted command 0x07 or 0x0F discards the queue contents and leaves exactly 0xFE, 0x21, in that order.
- R5: An accepted command 0x0E enqueues nothing and marks the next accepted command byte as LED data. That byte is discarded whatever its value, and the byte after it is decoded normally.
- R6: A command byte is accepted only when `tx_enable` is 1 and `chan_disable` is 0. Command values other than 0x01, 0x07, 0x0E and 0x0F change nothing.
- R7: The queue holds at most `DEPTH` bytes. A byte pushed while the queue is full is dropped, and the stored bytes are kept.
- R8: While the queue is empty, `rd_data` is 0x00 and an `rd_en` pulse has no effect.
- R9: Each lock key (`CAPS_CODE`, `NUM_CODE`) keeps a 2-bit state that starts at 0. A press flips bit 0 and a release flips bit 1. The event is dropped when a press leaves the state at 2 or a release leaves it at 3, so that press, release, press, release emits only the first press and the second release.
- R10: A key event in the same cycle as a flushing command is enqueued one cycle later, after the reply. If a second flushing command arrives in that later cycle, the held key byte is discarded.
- R11: `not_empty` is 1 exactly when at least one byte is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Channel transmitter enabled; commands are accepted only when set |
| chan_disable | input | 1 | Channel disabled; blocks commands when set |
| key_valid | input | 1 | Key event strobe |
| keycode | input | 7 | Keyboard code of the event |
| is_down | input | 1 | 1 for press, 0 for release |
| cmd_valid | input | 1 | Host command byte strobe |
| cmd_byte | input | 8 | Host command byte |
| rd_en | input | 1 | Pop the head byte |
| rd_data | output | 8 | Head byte, 0x00 when empty |
| not_empty | output | 1 | Queue holds at least one byte |

## Verification
The bench builds the block with `DEPTH` = 8 and leaves the lock codes at their defaults. The small depth lets a short burst of key presses fill the queue, so the drop-on-full path and pointer wrap are reached in a few dozen cycles. The default lock codes are used as they would be in the field. Expected bytes are derived from the requirements and compared in read order, and this includes the cycle-level collision between a key event and a flushing command.

// File: rtl/kbd_responder.sv
module kbd_responder #(
  parameter int DEPTH = 256,
  parameter logic [6:0] CAPS_CODE = 7'h77,
  parameter logic [6:0] NUM_CODE  = 7'h62
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_enable,
  input  logic       chan_disable,
  input  logic       key_valid,
  input  logic [6:0] keycode,
  input  logic       is_down,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       not_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic [CW-1:0] cnt;
  logic          led_pending;
  logic [1:0]    caps_st, num_st;
  logic          hold_v;
  logic [7:0]    hold_b;

  logic cmd_on, is_rst, is_lay, is_led, flush;
  assign cmd_on = cmd_valid && tx_enable && !chan_disable;
  assign is_rst = cmd_on && !led_pending && cmd_byte == 8'h01;
  assign is_lay = cmd_on && !led_pending && (cmd_byte == 8'h07 || cmd_byte == 8'h0F);
  assign is_led = cmd_on && !led_pending && cmd_byte == 8'h0E;
  assign flush  = is_rst || is_lay;

  logic       caps_hit, num_hit, lock_drop, key_ok;
  logic [1:0] flip, caps_nx, num_nx;
  logic [7:0] key_b;
  assign flip     = is_down ? 2'b01 : 2'b10;
  assign caps_hit = key_valid && keycode == CAPS_CODE;
  assign num_hit  = key_valid && keycode == NUM_CODE;
  assign caps_nx  = caps_st ^ flip;
  assign num_nx   = num_st ^ flip;
  assign lock_drop = (caps_hit && caps_nx == (is_down ? 2'd2 : 2'd3)) ||
                     (num_hit  && num_nx  == (is_down ? 2'd2 : 2'd3));
  assign key_ok = key_valid && !lock_drop;
  assign key_b  = {~is_down, keycode};

  logic [1:0] nb;
  logic [7:0] pb [3];
  always_comb begin
    nb = 2'd0;
    pb[0] = 8'h00; pb[1] = 8'h00; pb[2] = 8'h00;
    if (is_rst) begin
      nb = 2'd3; pb[0] = 8'hFF; pb[1] = 8'h04; pb[2] = 8'h7F;
    end else if (is_lay) begin
      nb = 2'd2; pb[0] = 8'hFE; pb[1] = 8'h21;
    end else begin
      if (hold_v) begin
        pb[0] = hold_b; nb = 2'd1;
      end
      if (key_ok) begin
        pb[nb] = key_b; nb = nb + 2'd1;
      end
    end
  end

  logic          pop;
  logic [CW-1:0] base_cnt, room;
  logic [AW-1:0] base_w;
  logic [1:0]    acc;
  assign pop      = rd_en && cnt != '0 && !flush;
  assign base_cnt = flush ? '0 : cnt - CW'(pop);
  assign base_w   = flush ? '0 : wptr;
  assign room     = FULL - base_cnt;
  assign acc      = (room < CW'(nb)) ? room[1:0] : nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0; wptr <= '0; cnt <= '0;
      led_pending <= 1'b0;
      caps_st <= 2'd0; num_st <= 2'd0;
      hold_v <= 1'b0; hold_b <= 8'h00;
    end else begin
      cnt  <= base_cnt + CW'(acc);
      wptr <= base_w + AW'(acc);
      rptr <= flush ? '0 : rptr + AW'(pop);
      if (cmd_on) led_pending <= is_led;
      if (caps_hit) caps_st <= caps_nx;
      if (num_hit) num_st <= num_nx;
      hold_v <= flush && key_ok;
      hold_b <= key_b;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 3; k++)
      if (k < int'(acc)) mem[base_w + AW'(k)] <= pb[k];
  end

  assign not_empty = cnt != '0;
  assign rd_data   = not_empty ? mem[rptr] : 8'h00;
endmodule

// File: rtl/kbd_responder_chk.sv
module kbd_responder_chk #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_enable,
  input logic          chan_disable,
  input logic          cmd_valid,
  input logic [7:0]    cmd_byte,
  input logic [7:0]    rd_data,
  input logic          not_empty,
  input logic          led_pending,
  input logic [CW-1:0] cnt
);
  logic acc_cmd;
  assign acc_cmd = cmd_valid && tx_enable && !chan_disable;

  assert_reset_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cmd && !led_pending && cmd_byte == 8'h01) |=> (not_empty && rd_data == 8'hFF));

  assert_layout_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cmd && !led_pending && (cmd_byte == 8'h07 || cmd_byte == 8'h0F))
      |=> (not_empty && rd_data == 8'hFE));

  assert_led_swallow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cmd && led_pending) |=> !led_pending);

  assert_cmd_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !acc_cmd) |=> $stable(led_pending));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !not_empty |-> rd_data == 8'h00);
endmodule

bind kbd_responder kbd_responder_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .chan_disable(chan_disable),
  .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .rd_data(rd_data),
  .not_empty(not_empty), .led_pending(led_pending), .cnt(cnt)
);

// File: tb/test_kbd_responder.sv
`timescale 1ns/1ps
module test_kbd_responder;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_enable = 1'b0, chan_disable = 1'b0;
  logic key_valid = 1'b0, is_down = 1'b0;
  logic [6:0] keycode = '0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_data;
  logic not_empty;

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  kbd_responder #(.DEPTH(DEPTH)) i_kbd_responder (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .chan_disable(chan_disable),
    .key_valid(key_valid), .keycode(keycode), .is_down(is_down),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .rd_en(rd_en), .rd_data(rd_data), .not_empty(not_empty)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic key(logic [6:0] c, logic d, bit emits);
    key_valid = 1'b1; keycode = c; is_down = d;
    @(posedge clk); #1;
    key_valid = 1'b0;
    @(negedge clk);
    if (emits) exp_q.push_back({~d, c});
  endtask

  task automatic cmd(logic [7:0] b);
    cmd_valid = 1'b1; cmd_byte = b;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain(string req);
    while (not_empty) begin
      if (exp_q.size() == 0) begin
        check(req, rd_data, 8'hxx);
      end else begin
        check(req, rd_data, exp_q.pop_front());
      end
      rd_en = 1'b1;
      @(posedge clk); #1;
      rd_en = 1'b0;
      @(negedge clk);
    end
    check({req, " leftover"}, 8'(exp_q.size()), 8'd0);
    exp_q.delete();
    check({req, " R11 empty"}, {7'd0, not_empty}, 8'd0);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 not_empty", {7'd0, not_empty}, 8'd0);
    check("R1 rd_data", rd_data, 8'h00);

    key(7'h12, 1, 1); key(7'h12, 0, 1); key(7'h7F, 1, 1);
    check("R11 not_empty", {7'd0, not_empty}, 8'd1);
    drain("R2");

    key(7'h77, 1, 1); key(7'h77, 0, 0); key(7'h77, 1, 0); key(7'h77, 0, 1);
    key(7'h62, 1, 1); key(7'h62, 0, 0); key(7'h62, 1, 0); key(7'h62, 0, 1);
    key(7'h77, 1, 1);
    drain("R9");

    tx_enable = 1'b1;
    key(7'h05, 1, 1);
    cmd(8'h01);
    exp_q.delete(); exp_q.push_back(8'hFF); exp_q.push_back(8'h04); exp_q.push_back(8'h7F);
    drain("R3");

    key(7'h06, 1, 1);
    cmd(8'h07);
    exp_q.delete(); exp_q.push_back(8'hFE); exp_q.push_back(8'h21);
    drain("R4 07");
    cmd(8'h0F);
    exp_q.push_back(8'hFE); exp_q.push_back(8'h21);
    drain("R4 0F");

    cmd(8'h0E); cmd(8'h01);
    check("R5 swallowed", {7'd0, not_empty}, 8'd0);
    cmd(8'h01);
    exp_q.push_back(8'hFF); exp_q.push_back(8'h04); exp_q.push_back(8'h7F);
    drain("R5");

    key(7'h33, 1, 1);
    tx_enable = 1'b0; cmd(8'h01); cmd(8'h0E);
    tx_enable = 1'b1; chan_disable = 1'b1; cmd(8'h07);
    chan_disable = 1'b0; cmd(8'h55);
    drain("R6 gated");
    cmd(8'h07);
    exp_q.push_back(8'hFE); exp_q.push_back(8'h21);
    drain("R6 led not armed");

    for (int i = 0; i < 10; i++) key(7'(8'h20 + i), 1, i < DEPTH);
    check("R7 full", {7'd0, not_empty}, 8'd1);
    drain("R7");

    check("R8 empty data", rd_data, 8'h00);
    rd_en = 1'b1; @(posedge clk); #1; rd_en = 1'b0; @(negedge clk);
    check("R8 pop empty", {7'd0, not_empty}, 8'd0);
    key(7'h41, 0, 1);
    drain("R8");

    key_valid = 1'b1; keycode = 7'h2A; is_down = 1'b1;
    cmd_valid = 1'b1; cmd_byte = 8'h01;
    @(posedge clk); #1;
    key_valid = 1'b0; cmd_valid = 1'b0;
    @(negedge clk);
    check("R10 head", rd_data, 8'hFF);
    exp_q.push_back(8'hFF); exp_q.push_back(8'h04); exp_q.push_back(8'h7F);
    exp_q.push_back(8'h2A);
    drain("R10 held");

    key_valid = 1'b1; keycode = 7'h2B; is_down = 1'b0;
    cmd_valid = 1'b1; cmd_byte = 8'h01;
    @(posedge clk); #1;
    key_valid = 1'b0; cmd_byte = 8'h07;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    exp_q.push_back(8'hFE); exp_q.push_back(8'h21);
    drain("R10 flushed");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule